// File: doc/BRIEF.md
# DS0 Channel Processor with Robbed-Bit Signalling

This block sits between the system side and the line side of a T1 framer. It applies per-channel treatment to the 24 DS0 timeslots in both directions. Every channel byte passes through a one-stage valid/ready pipeline, one stage for transmit and one for receive. The byte travels with its channel index, and on transmit also with its frame index within the superframe. On transmit the block can replace the least significant bit with a signalling bit, then it may invert the byte. On receive it may invert the byte, then it may replace it with the byte most recently transmitted on the looped channel.

Two control words are held for each channel and written through a plain register port. The first word holds the polarity, loopback and data-channel flags. The second word holds the four signalling bits A, B, C and D. Two static pins select the superframe format and gate the data-channel flag. The stream rules are as follows. A byte is accepted on a clock edge where `*_in_valid` and `*_in_ready` are both high. `*_in_ready` is high whenever the output register is empty or being drained. A result that is held back by `*_out_ready` low stays unchanged until it is taken.

Top module: `ds0_chan_proc`

## Requirements
- R1: After reset both output valids are low, both input readies are high, and every control word reads as zero. As a result every channel starts with the polarity flag clear.
- R2: A write sets the addressed word of channel `cfg_chan`. When `cfg_sel`=0 the write goes to the control word: bit 2 is polarity, bit 1 is loop, bit 0 is data channel. When `cfg_sel`=1 it goes to the signalling word: bit 3 is A, bit 2 is B, bit 1 is C, bit 0 is D. `cfg_rdata` returns the addressed word, and its unused upper bits read as zero.
- R3: When the polarity flag of a channel is clear, all 8 bits of its bytes are inverted in both directions. When the flag is set, the bytes pass unchanged.
- R4: ESF format (`esf_mode`=1) uses frame indices 0 to 23. The transmit byte's bit 0 is replaced by A at frame 5, B at frame 11, C at frame 17 and D at frame 23. At all other frames bit 0 is kept.
- R5: 12-frame format (`esf_mode`=0) replaces bit 0 with A at frame indices 5 and 17, and with B at indices 11 and 23. C and D have no effect.
- R6: When a channel's data-channel flag is set and `dch_gate` is low, no signalling is inserted in that channel. When `dch_gate` is high, the flag is ignored and signalling is inserted.
- R7: On transmit, inversion is applied after signalling insertion.
- R8: The receive byte of the looped channel is replaced by that channel's last transmitted line byte. This byte is taken after the transmit inversion, and receive inversion does not apply to it. The transmit path is not changed by loopback.
- R9: If several loop flags are set, only the lowest-numbered looped channel is substituted. The other channels with a loop flag are treated as not looped.
- R10: When a transmit byte and a receive byte of the looped channel are accepted in the same cycle, the receive output carries the transmit byte from that same cycle.
- R11: Each direction registers its result one cycle after acceptance. While `*_out_ready` is low and the output is valid, the output data and channel do not change and `*_in_ready` is low.
- R12: Each output carries the channel index of the byte that produced it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| esf_mode | input | 1 | 1 selects the 24-frame format, 0 selects the 12-frame format |
| dch_gate | input | 1 | High disables the per-channel data-channel flag |
| cfg_we | input | 1 | Write strobe for the control words |
| cfg_sel | input | 1 | 0 selects the control word, 1 selects the signalling word |
| cfg_chan | input | 5 | Channel addressed by the register port |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of the addressed word |
| tx_in_valid | input | 1 | Transmit byte offered |
| tx_in_ready | output | 1 | Transmit byte can be accepted |
| tx_in_chan | input | 5 | Channel index of the transmit byte |
| tx_in_frame | input | 5 | Frame index within the superframe |
| tx_in_data | input | 8 | Transmit byte from the system side |
| tx_out_valid | output | 1 | Line-side transmit byte available |
| tx_out_ready | input | 1 | Line side takes the transmit byte |
| tx_out_chan | output | 5 | Channel index of the transmit output |
| tx_out_data | output | 8 | Processed transmit byte |
| rx_in_valid | input | 1 | Receive byte offered |
| rx_in_ready | output | 1 | Receive byte can be accepted |
| rx_in_chan | input | 5 | Channel index of the receive byte |
| rx_in_data | input | 8 | Receive byte from the line side |
| rx_out_valid | output | 1 | System-side receive byte available |
| rx_out_ready | input | 1 | System side takes the receive byte |
| rx_out_chan | output | 5 | Channel index of the receive output |
| rx_out_data | output | 8 | Processed receive byte |

## Verification
Transmit capture of the loopback byte and receive substitution of that same channel can happen in one clock cycle. To provoke this, the bench drives both inputs for the looped channel on the same edge. It then expects the receive output to equal the transmit output of that edge, not the older stored byte. A second collision arises between a stalled output and a new input offered against it. The bench holds `tx_out_ready` low while a second byte waits, and checks two things: the first result stays frozen, and the second result appears exactly one edge after the stall is released.

// File: rtl/ds0_pkg.sv
package ds0_pkg;
  localparam int SF_FRAMES = 24;
  localparam int FR_W      = $clog2(SF_FRAMES);

  typedef struct packed {
    logic pol;
    logic loop;
    logic dch;
  } chan_ctl_t;

  // returns {hit, bit}: whether this frame carries signalling and which bit
  function automatic logic [1:0] rbs_slot(input logic esf,
                                          input logic [FR_W-1:0] fr,
                                          input logic [3:0] abcd);
    logic [1:0] r;
    r = 2'b00;
    case (fr)
      FR_W'(5):  r = {1'b1, abcd[3]};
      FR_W'(11): r = {1'b1, abcd[2]};
      FR_W'(17): r = {1'b1, esf ? abcd[1] : abcd[3]};
      FR_W'(23): r = {1'b1, esf ? abcd[0] : abcd[2]};
      default:   r = 2'b00;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/ds0_stage.sv
module ds0_stage #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/ds0_ctrl_regs.sv
module ds0_ctrl_regs
  import ds0_pkg::*;
#(
  parameter int NCH = 24,
  parameter int CHW = 5,
  parameter int BW  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             sel,
  input  logic [CHW-1:0]   chan,
  input  logic [BW-1:0]    wdata,
  output logic [BW-1:0]    rdata,
  output logic [NCH-1:0]   pol_v,
  output logic [NCH-1:0]   dch_v,
  output logic [4*NCH-1:0] sig_v,
  output logic             loop_on,
  output logic [CHW-1:0]   loop_idx
);
  chan_ctl_t  ctl_q [NCH];
  logic [3:0] sig_q [NCH];
  logic       in_rng;

  assign in_rng = int'(chan) < NCH;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        ctl_q[i] <= '0;
        sig_q[i] <= '0;
      end
    end else if (we && in_rng) begin
      if (sel) sig_q[chan] <= wdata[3:0];
      else     ctl_q[chan] <= wdata[2:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (in_rng) begin
      if (sel) rdata[3:0] = sig_q[chan];
      else     rdata[2:0] = ctl_q[chan];
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_flat
    assign pol_v[g]          = ctl_q[g].pol;
    assign dch_v[g]          = ctl_q[g].dch;
    assign sig_v[4*g +: 4]   = sig_q[g];
  end

  // lowest-numbered loop flag wins
  always_comb begin
    loop_on  = 1'b0;
    loop_idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (ctl_q[i].loop) begin
        loop_on  = 1'b1;
        loop_idx = CHW'(i);
      end
    end
  end
endmodule

// File: rtl/ds0_tx_path.sv
module ds0_tx_path
  import ds0_pkg::*;
#(
  parameter int NCH = 24,
  parameter int CHW = 5,
  parameter int BW  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             esf_mode,
  input  logic             dch_gate,
  input  logic [NCH-1:0]   pol_v,
  input  logic [NCH-1:0]   dch_v,
  input  logic [4*NCH-1:0] sig_v,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [CHW-1:0]   in_chan,
  input  logic [FR_W-1:0]  in_frame,
  input  logic [BW-1:0]    in_data,
  output logic             fire,
  output logic [BW-1:0]    proc,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [CHW-1:0]   out_chan,
  output logic [BW-1:0]    out_data
);
  logic       in_rng, pol, robbed;
  logic [1:0] slot;
  int         ci;

  always_comb begin
    in_rng = int'(in_chan) < NCH;
    ci     = in_rng ? int'(in_chan) : 0;
    pol    = in_rng ? pol_v[ci] : 1'b1;
    robbed = in_rng && (!dch_v[ci] || dch_gate);
    slot   = rbs_slot(esf_mode, in_frame, sig_v[4*ci +: 4]);
    proc   = in_data;
    if (robbed && slot[1]) proc[0] = slot[0];
    if (!pol) proc = ~proc;
  end

  assign fire = in_valid && in_ready;

  ds0_stage #(.W(CHW + BW)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  ({in_chan, proc}),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data ({out_chan, out_data})
  );
endmodule

// File: rtl/ds0_rx_path.sv
module ds0_rx_path #(
  parameter int NCH = 24,
  parameter int CHW = 5,
  parameter int BW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pol_v,
  input  logic           loop_on,
  input  logic [CHW-1:0] loop_idx,
  input  logic           tx_fire,
  input  logic [CHW-1:0] tx_chan,
  input  logic [BW-1:0]  tx_proc,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [CHW-1:0] in_chan,
  input  logic [BW-1:0]  in_data,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [CHW-1:0] out_chan,
  output logic [BW-1:0]  out_data
);
  logic [BW-1:0] loop_q, loop_fwd, proc;
  logic          in_rng, cap;
  int            ci;

  assign cap      = tx_fire && loop_on && (tx_chan == loop_idx);
  assign loop_fwd = cap ? tx_proc : loop_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   loop_q <= '0;
    else if (cap) loop_q <= tx_proc;
  end

  always_comb begin
    in_rng = int'(in_chan) < NCH;
    ci     = in_rng ? int'(in_chan) : 0;
    proc   = (in_rng && !pol_v[ci]) ? ~in_data : in_data;
    if (in_rng && loop_on && in_chan == loop_idx) proc = loop_fwd;
  end

  ds0_stage #(.W(CHW + BW)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  ({in_chan, proc}),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data ({out_chan, out_data})
  );
endmodule

// File: rtl/ds0_chan_proc.sv
module ds0_chan_proc
  import ds0_pkg::*;
#(
  parameter int NCH = 24,
  parameter int BW  = 8,
  localparam int CHW = $clog2(NCH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            esf_mode,
  input  logic            dch_gate,
  input  logic            cfg_we,
  input  logic            cfg_sel,
  input  logic [CHW-1:0]  cfg_chan,
  input  logic [BW-1:0]   cfg_wdata,
  output logic [BW-1:0]   cfg_rdata,
  input  logic            tx_in_valid,
  output logic            tx_in_ready,
  input  logic [CHW-1:0]  tx_in_chan,
  input  logic [FR_W-1:0] tx_in_frame,
  input  logic [BW-1:0]   tx_in_data,
  output logic            tx_out_valid,
  input  logic            tx_out_ready,
  output logic [CHW-1:0]  tx_out_chan,
  output logic [BW-1:0]   tx_out_data,
  input  logic            rx_in_valid,
  output logic            rx_in_ready,
  input  logic [CHW-1:0]  rx_in_chan,
  input  logic [BW-1:0]   rx_in_data,
  output logic            rx_out_valid,
  input  logic            rx_out_ready,
  output logic [CHW-1:0]  rx_out_chan,
  output logic [BW-1:0]   rx_out_data
);
  logic [NCH-1:0]   pol_v, dch_v;
  logic [4*NCH-1:0] sig_v;
  logic             loop_on, tx_fire;
  logic [CHW-1:0]   loop_idx;
  logic [BW-1:0]    tx_proc;

  ds0_ctrl_regs #(.NCH(NCH), .CHW(CHW), .BW(BW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .chan(cfg_chan),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .pol_v(pol_v), .dch_v(dch_v),
    .sig_v(sig_v), .loop_on(loop_on), .loop_idx(loop_idx)
  );

  ds0_tx_path #(.NCH(NCH), .CHW(CHW), .BW(BW)) u_tx (
    .clk(clk), .rst_n(rst_n), .esf_mode(esf_mode), .dch_gate(dch_gate),
    .pol_v(pol_v), .dch_v(dch_v), .sig_v(sig_v),
    .in_valid(tx_in_valid), .in_ready(tx_in_ready), .in_chan(tx_in_chan),
    .in_frame(tx_in_frame), .in_data(tx_in_data), .fire(tx_fire), .proc(tx_proc),
    .out_valid(tx_out_valid), .out_ready(tx_out_ready), .out_chan(tx_out_chan),
    .out_data(tx_out_data)
  );

  ds0_rx_path #(.NCH(NCH), .CHW(CHW), .BW(BW)) u_rx (
    .clk(clk), .rst_n(rst_n), .pol_v(pol_v), .loop_on(loop_on), .loop_idx(loop_idx),
    .tx_fire(tx_fire), .tx_chan(tx_in_chan), .tx_proc(tx_proc),
    .in_valid(rx_in_valid), .in_ready(rx_in_ready), .in_chan(rx_in_chan),
    .in_data(rx_in_data), .out_valid(rx_out_valid), .out_ready(rx_out_ready),
    .out_chan(rx_out_chan), .out_data(rx_out_data)
  );
endmodule

// File: rtl/ds0_chan_proc_chk.sv
module ds0_chan_proc_chk #(
  parameter int CHW = 5,
  parameter int BW  = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_we,
  input logic           cfg_sel,
  input logic [CHW-1:0] cfg_chan,
  input logic [BW-1:0]  cfg_wdata,
  input logic [BW-1:0]  cfg_rdata,
  input logic           tx_in_valid,
  input logic           tx_in_ready,
  input logic [CHW-1:0] tx_in_chan,
  input logic           tx_out_valid,
  input logic           tx_out_ready,
  input logic [CHW-1:0] tx_out_chan,
  input logic [BW-1:0]  tx_out_data,
  input logic           rx_in_valid,
  input logic           rx_in_ready,
  input logic [CHW-1:0] rx_in_chan,
  input logic           rx_out_valid,
  input logic           rx_out_ready,
  input logic [CHW-1:0] rx_out_chan,
  input logic [BW-1:0]  rx_out_data
);
  assert_tx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_out_valid && !tx_out_ready |=> tx_out_valid && $stable(tx_out_data) && $stable(tx_out_chan));

  assert_rx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_out_valid && !rx_out_ready |=> rx_out_valid && $stable(rx_out_data) && $stable(rx_out_chan));

  assert_tx_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_out_valid && !tx_out_ready |-> !tx_in_ready);

  assert_cfg_rdback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_we) && int'($past(cfg_chan)) < 24 && cfg_chan == $past(cfg_chan) && cfg_sel == $past(cfg_sel)
    |-> cfg_rdata == ($past(cfg_wdata) & (cfg_sel ? 8'h0F : 8'h07)));

  assert_tx_chan_R12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_in_valid && tx_in_ready |=> tx_out_valid && tx_out_chan == $past(tx_in_chan));

  assert_rx_chan_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_in_valid && rx_in_ready |=> rx_out_valid && rx_out_chan == $past(rx_in_chan));
endmodule

bind ds0_chan_proc ds0_chan_proc_chk #(.CHW(CHW), .BW(BW)) u_chk (.*);

// File: tb/sim_ds0_chan_proc.sv
module sim_ds0_chan_proc;
  logic clk = 1'b0, rst_n = 1'b0;
  logic esf_mode = 1'b1, dch_gate = 1'b0;
  logic cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [4:0] cfg_chan = '0;
  logic [7:0] cfg_wdata = '0, cfg_rdata;
  logic tx_in_valid = 1'b0, tx_in_ready, tx_out_valid, tx_out_ready = 1'b1;
  logic [4:0] tx_in_chan = '0, tx_in_frame = '0, tx_out_chan;
  logic [7:0] tx_in_data = '0, tx_out_data;
  logic rx_in_valid = 1'b0, rx_in_ready, rx_out_valid, rx_out_ready = 1'b1;
  logic [4:0] rx_in_chan = '0, rx_out_chan;
  logic [7:0] rx_in_data = '0, rx_out_data;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ds0_chan_proc u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input int ch, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_chan = 5'(ch); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send_tx(input int ch, input int fr, input logic [7:0] d);
    @(negedge clk);
    tx_in_valid = 1'b1; tx_in_chan = 5'(ch); tx_in_frame = 5'(fr); tx_in_data = d;
    @(negedge clk);
    tx_in_valid = 1'b0;
  endtask

  task automatic send_rx(input int ch, input logic [7:0] d);
    @(negedge clk);
    rx_in_valid = 1'b1; rx_in_chan = 5'(ch); rx_in_data = d;
    @(negedge clk);
    rx_in_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 tx_out_valid", tx_out_valid, 0);
    chk("R1 rx_out_valid", rx_out_valid, 0);
    chk("R1 tx_in_ready", tx_in_ready, 1);
    cfg_sel = 1'b0; cfg_chan = 5'd0; #1 chk("R1 ctl word ch0", cfg_rdata, 0);
    cfg_sel = 1'b1; cfg_chan = 5'd23; #1 chk("R1 sig word ch23", cfg_rdata, 0);
  endtask

  task automatic t_cfg;
    wr(1'b0, 7, 8'hFF);
    cfg_sel = 1'b0; cfg_chan = 5'd7; #1 chk("R2 ctl reserved zero", cfg_rdata, 8'h07);
    wr(1'b1, 7, 8'hAB);
    cfg_sel = 1'b1; cfg_chan = 5'd7; #1 chk("R2 sig reserved zero", cfg_rdata, 8'h0B);
    wr(1'b0, 7, 8'h00);
  endtask

  task automatic t_pol;
    send_tx(3, 0, 8'h5A); chk("R3 tx invert", tx_out_data, 8'hA5);
    send_rx(3, 8'h3C);    chk("R3 rx invert", rx_out_data, 8'hC3);
    wr(1'b0, 3, 8'h04);
    send_tx(3, 0, 8'h5A); chk("R3 tx pass", tx_out_data, 8'h5A);
    send_rx(3, 8'h3C);    chk("R3 rx pass", rx_out_data, 8'h3C);
  endtask

  task automatic t_esf;
    esf_mode = 1'b1;
    wr(1'b0, 4, 8'h04);
    wr(1'b1, 4, 8'b1010);
    send_tx(4, 5, 8'hFE);  chk("R4 frame5 A", tx_out_data, 8'hFF);
    send_tx(4, 11, 8'hFF); chk("R4 frame11 B", tx_out_data, 8'hFE);
    send_tx(4, 17, 8'hFE); chk("R4 frame17 C", tx_out_data, 8'hFF);
    send_tx(4, 23, 8'hFF); chk("R4 frame23 D", tx_out_data, 8'hFE);
    send_tx(4, 6, 8'hFE);  chk("R4 non-signalling frame", tx_out_data, 8'hFE);
  endtask

  task automatic t_d4;
    esf_mode = 1'b0;
    wr(1'b1, 4, 8'b1000);
    send_tx(4, 5, 8'h00);  chk("R5 frame5 A", tx_out_data, 8'h01);
    send_tx(4, 17, 8'h00); chk("R5 frame17 A", tx_out_data, 8'h01);
    send_tx(4, 11, 8'h01); chk("R5 frame11 B", tx_out_data, 8'h00);
    wr(1'b1, 4, 8'b0011);
    send_tx(4, 23, 8'h01); chk("R5 frame23 B, D ignored", tx_out_data, 8'h00);
    send_tx(4, 17, 8'h01); chk("R5 frame17 A, C ignored", tx_out_data, 8'h00);
    esf_mode = 1'b1;
  endtask

  task automatic t_dch;
    wr(1'b0, 4, 8'h05);
    wr(1'b1, 4, 8'b1000);
    dch_gate = 1'b0;
    send_tx(4, 5, 8'h00); chk("R6 data channel no robbing", tx_out_data, 8'h00);
    dch_gate = 1'b1;
    send_tx(4, 5, 8'h00); chk("R6 gate high overrides", tx_out_data, 8'h01);
    dch_gate = 1'b0;
  endtask

  task automatic t_order;
    wr(1'b1, 5, 8'b1000);
    send_tx(5, 5, 8'h00); chk("R7 insert then invert", tx_out_data, 8'hFE);
  endtask

  task automatic t_loop;
    wr(1'b0, 9, 8'h02);
    send_tx(9, 0, 8'h33); chk("R8 tx unaffected", tx_out_data, 8'hCC);
    send_rx(9, 8'h77);    chk("R8 rx replaced", rx_out_data, 8'hCC);
    chk("R12 rx chan", rx_out_chan, 9);
    send_rx(8, 8'h77);    chk("R8 other chan normal", rx_out_data, 8'h88);
  endtask

  task automatic t_multi;
    wr(1'b0, 2, 8'h06);
    send_tx(2, 0, 8'h44); chk("R9 tx ch2", tx_out_data, 8'h44);
    chk("R12 tx chan", tx_out_chan, 2);
    send_rx(9, 8'h77);    chk("R9 higher loop ignored", rx_out_data, 8'h88);
    send_rx(2, 8'h11);    chk("R9 lowest looped", rx_out_data, 8'h44);
    wr(1'b0, 9, 8'h00);
  endtask

  task automatic t_same;
    @(negedge clk);
    tx_in_valid = 1'b1; tx_in_chan = 5'd2; tx_in_frame = 5'd0; tx_in_data = 8'h12;
    rx_in_valid = 1'b1; rx_in_chan = 5'd2; rx_in_data = 8'h99;
    @(negedge clk);
    tx_in_valid = 1'b0; rx_in_valid = 1'b0;
    chk("R10 tx same cycle", tx_out_data, 8'h12);
    chk("R10 rx forwarded", rx_out_data, 8'h12);
    wr(1'b0, 2, 8'h04);
  endtask

  task automatic t_bp;
    @(negedge clk); tx_out_ready = 1'b0;
    send_tx(0, 0, 8'h10);
    chk("R11 valid after one edge", tx_out_valid, 1);
    chk("R11 data", tx_out_data, 8'hEF);
    chk("R11 in_ready low", tx_in_ready, 0);
    tx_in_valid = 1'b1; tx_in_chan = 5'd1; tx_in_frame = 5'd0; tx_in_data = 8'h20;
    @(negedge clk); @(negedge clk);
    chk("R11 held data", tx_out_data, 8'hEF);
    chk("R11 held chan", tx_out_chan, 0);
    tx_out_ready = 1'b1;
    @(negedge clk);
    tx_in_valid = 1'b0;
    chk("R11 next data", tx_out_data, 8'hDF);
    chk("R12 next chan", tx_out_chan, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_pol();
    t_esf();
    t_d4();
    t_dch();
    t_order();
    t_loop();
    t_multi();
    t_same();
    t_bp();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule